// File: doc/BRIEF.md
# Interleaved Transfer Address Sequencer

This block produces the byte-address stream of a patterned copy between a source and a destination. Software first loads a small table of chunk descriptors (a byte count and a skip distance per entry) and a handful of transfer settings. A start pulse then makes the block walk the pattern and hand out one source/destination byte-address pair per accepted beat on a valid/ready stream. A single-cycle done pulse follows the last pair.

The pattern is a frame: the first N table entries, taken in order. The frame is repeated a programmed number of times. Each side has its own pair of flags. One flag freezes or advances the address. The other adds or drops the per-chunk skips. From one table the block can therefore gather scattered data into a packed buffer, spread packed data into a strided layout, or feed a fixed-address FIFO. The table and flags are meant to be set once. Only the two start addresses change between transfers.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `busy` and `done` are low.
- R2: The first pair of a transfer equals the programmed source and destination start addresses. Inside a chunk, each side whose advance flag is set moves up by one byte per accepted pair.
- R3: With source advance and source skip both set, the chunk's skip value is added to the source address after the last byte of that chunk. This includes the last entry of a frame, whose skip is applied before the first chunk of the next frame.
- R4: With source advance set and source skip clear, source addresses are contiguous across chunk and frame boundaries.
- R5: With source advance clear, every source address of the transfer equals the source start address, whatever the source skip flag says.
- R6: The destination follows the rules of R2 to R5 using its own two flags, independently of the source.
- R7: One transfer emits the entries 0..N-1 in order, repeated F times. The total is F times the sum of the sizes in pairs, and no pair follows the last one.
- R8: An entry of size zero emits no pair but still adds its skip on each side where skips are active.
- R9: A start with frame count 0 or entry count 0 raises `done` in the next cycle. It emits no pair, and `busy` stays low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `src_addr` and `dst_addr` hold their values.
- R11: A start pulse while `busy` is high has no effect on the running transfer.
- R12: `done` is high for exactly one cycle, while `out_valid` and `busy` are low. When the final entry is non-empty, `done` rises in the cycle after the last accepted pair.
- R13: Configuration writes use `cfg_sel` codes 0 = source start, 1 = destination start, 2 = frame count, 3 = entry count, and 4 = flags. The flag bits are bit0 source advance, bit1 source skip, bit2 destination advance and bit3 destination skip. The table, counts and flags persist across transfers, so reloading only the start addresses repeats the pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a transfer setting |
| cfg_sel | input | 3 | Setting selector (codes in R13) |
| cfg_data | input | ADDR_W (32) | Setting value |
| tbl_we | input | 1 | Write strobe for a chunk descriptor |
| tbl_idx | input | IDX_W (4) | Descriptor index |
| tbl_size | input | LEN_W (16) | Chunk byte count |
| tbl_gap | input | LEN_W (16) | Skip added after the chunk |
| start | input | 1 | Begin a transfer (ignored while busy) |
| out_valid | output | 1 | An address pair is offered |
| out_ready | input | 1 | Consumer accepts the pair |
| src_addr | output | ADDR_W (32) | Source byte address |
| dst_addr | output | ADDR_W (32) | Destination byte address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Some properties can be checked on every cycle. These are the stall hold of the output pair, the single-cycle done pulse with the stream idle, the early done for empty transfers, the frozen source address when source advance is clear, and the one-byte source step in contiguous mode. The ordering of entries, the placement of skips at chunk and frame boundaries, the handling of zero-size entries, and the total pair count depend on the whole table. Only the bench's scenarios can show them, by comparing every accepted pair with a pattern model built from the programmed table. The same holds for the immunity of a running transfer to a second start, and for reuse of the table after only the start addresses are reloaded.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   typedef enum logic [2:0] {
      SEL_SRC_BASE = 3'd0,
      SEL_DST_BASE = 3'd1,
      SEL_FRAMES   = 3'd2,
      SEL_ENTRIES  = 3'd3,
      SEL_FLAGS    = 3'd4
   } cfg_sel_e;

   // packed so that src_adv is bit 0 and dst_skip is bit 3
   typedef struct packed {
      logic dst_skip;
      logic dst_adv;
      logic src_skip;
      logic src_adv;
   } side_flags_t;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;

endpackage

// File: rtl/ilv_chunk_table.sv
module ilv_chunk_table #(
   parameter int DEPTH = 16,
   parameter int LEN_W = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [LEN_W-1:0] wr_size,
   input  logic [LEN_W-1:0] wr_gap,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [LEN_W-1:0] rd_size,
   output logic [LEN_W-1:0] rd_gap
);

   logic [LEN_W-1:0] size_q [DEPTH];
   logic [LEN_W-1:0] gap_q  [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q[e] <= '0;
            gap_q[e]  <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            size_q[e] <= wr_size;
            gap_q[e]  <= wr_gap;
         end
      end
   end

   always_comb begin
      rd_size = '0;
      rd_gap  = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (rd_idx == IDX_W'(e)) begin
            rd_size = size_q[e];
            rd_gap  = gap_q[e];
         end
      end
   end

endmodule

// File: rtl/ilv_side_stepper.sv
module ilv_side_stepper #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv_byte,
   input  logic              chunk_end,
   input  logic [LEN_W-1:0]  gap,
   input  logic              adv_en,
   input  logic              skip_en,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] byte_step;
   logic [ADDR_W-1:0] skip_step;

   always_comb begin
      byte_step = (adv_en && adv_byte) ? ADDR_W'(1) : '0;
      skip_step = (adv_en && skip_en && chunk_end) ? ADDR_W'(gap) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= base;
      else
         addr <= addr + byte_step + skip_step;
   end

endmodule

// File: rtl/ilv_walk_ctrl.sv
module ilv_walk_ctrl
   import ilv_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int IDX_W = 4,
   parameter int CNT_W = 5,
   parameter int FRM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [FRM_W-1:0] frames,
   input  logic [CNT_W-1:0] entries,
   input  logic [LEN_W-1:0] cur_size,
   input  logic             out_ready,
   output logic [IDX_W-1:0] rd_idx,
   output logic             out_valid,
   output logic             load,
   output logic             adv_byte,
   output logic             chunk_end,
   output logic             busy,
   output logic             done
);

   walk_state_e      state_q;
   logic [IDX_W-1:0] idx_q;
   logic [FRM_W-1:0] frame_q;
   logic [LEN_W-1:0] byte_q;

   logic in_run, empty_chunk, last_byte, last_entry, last_frame, finish, empty_req;

   always_comb begin
      in_run      = (state_q == WALK_RUN);
      empty_chunk = (cur_size == '0);
      out_valid   = in_run && !empty_chunk;
      adv_byte    = out_valid && out_ready;
      last_byte   = (byte_q == cur_size - LEN_W'(1));
      chunk_end   = in_run && (empty_chunk || (adv_byte && last_byte));
      last_entry  = ((CNT_W'(idx_q) + CNT_W'(1)) == entries);
      last_frame  = ((frame_q + FRM_W'(1)) == frames);
      finish      = chunk_end && last_entry && last_frame;
      empty_req   = (frames == '0) || (entries == '0);
      load        = !in_run && start && !empty_req;
      busy        = in_run;
      rd_idx      = idx_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WALK_IDLE;
         idx_q   <= '0;
         frame_q <= '0;
         byte_q  <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!in_run) begin
            if (load) begin
               state_q <= WALK_RUN;
               idx_q   <= '0;
               frame_q <= '0;
               byte_q  <= '0;
            end else if (start) begin
               done <= 1'b1;
            end
         end else begin
            if (adv_byte)
               byte_q <= last_byte ? '0 : byte_q + LEN_W'(1);
            if (chunk_end) begin
               if (last_entry) begin
                  idx_q   <= '0;
                  frame_q <= frame_q + FRM_W'(1);
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            if (finish) begin
               state_q <= WALK_IDLE;
               done    <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
   import ilv_pkg::*;
#(
   parameter  int ADDR_W = 32,
   parameter  int LEN_W  = 16,
   parameter  int DEPTH  = 16,
   parameter  int FRM_W  = 16,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [LEN_W-1:0]  tbl_size,
   input  logic [LEN_W-1:0]  tbl_gap,
   input  logic              start,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              busy,
   output logic              done
);

   localparam int SIDES = 2;

   if (DEPTH < 2) begin : g_bad_depth
      $error("ilv_addr_gen: DEPTH must be at least 2");
   end
   if (ADDR_W < LEN_W) begin : g_bad_width
      $error("ilv_addr_gen: ADDR_W must not be narrower than LEN_W");
   end
   if (FRM_W > ADDR_W || CNT_W > ADDR_W) begin : g_bad_count
      $error("ilv_addr_gen: counts must fit in cfg_data");
   end

   logic [ADDR_W-1:0] src_base_q, dst_base_q;
   logic [FRM_W-1:0]  frames_q;
   logic [CNT_W-1:0]  entries_q;
   side_flags_t       flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_base_q <= '0;
         dst_base_q <= '0;
         frames_q   <= '0;
         entries_q  <= '0;
         flags_q    <= '0;
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_sel))
            SEL_SRC_BASE: src_base_q <= cfg_data;
            SEL_DST_BASE: dst_base_q <= cfg_data;
            SEL_FRAMES:   frames_q   <= cfg_data[FRM_W-1:0];
            SEL_ENTRIES:  entries_q  <= cfg_data[CNT_W-1:0];
            SEL_FLAGS:    flags_q    <= side_flags_t'(cfg_data[3:0]);
            default: ;
         endcase
      end
   end

   logic [IDX_W-1:0] rd_idx;
   logic [LEN_W-1:0] cur_size, cur_gap;
   logic             load, adv_byte, chunk_end;

   ilv_chunk_table #(.DEPTH(DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_idx  (tbl_idx),
      .wr_size (tbl_size),
      .wr_gap  (tbl_gap),
      .rd_idx  (rd_idx),
      .rd_size (cur_size),
      .rd_gap  (cur_gap)
   );

   ilv_walk_ctrl #(.LEN_W(LEN_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .FRM_W(FRM_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .frames    (frames_q),
      .entries   (entries_q),
      .cur_size  (cur_size),
      .out_ready (out_ready),
      .rd_idx    (rd_idx),
      .out_valid (out_valid),
      .load      (load),
      .adv_byte  (adv_byte),
      .chunk_end (chunk_end),
      .busy      (busy),
      .done      (done)
   );

   logic [ADDR_W-1:0] side_base [SIDES];
   logic [ADDR_W-1:0] side_addr [SIDES];
   logic              side_adv  [SIDES];
   logic              side_skip [SIDES];

   always_comb begin
      side_base[0] = src_base_q;
      side_base[1] = dst_base_q;
      side_adv[0]  = flags_q.src_adv;
      side_adv[1]  = flags_q.dst_adv;
      side_skip[0] = flags_q.src_skip;
      side_skip[1] = flags_q.dst_skip;
   end

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      ilv_side_stepper #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .base      (side_base[s]),
         .adv_byte  (adv_byte),
         .chunk_end (chunk_end),
         .gap       (cur_gap),
         .adv_en    (side_adv[s]),
         .skip_en   (side_skip[s]),
         .addr      (side_addr[s])
      );
   end

   assign src_addr = side_addr[0];
   assign dst_addr = side_addr[1];

endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk #(
   parameter int ADDR_W = 32,
   parameter int FRM_W  = 16,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] src_addr,
   input logic [ADDR_W-1:0] dst_addr,
   input logic              busy,
   input logic              done,
   input logic [3:0]        flags,
   input logic [ADDR_W-1:0] src_base,
   input logic [FRM_W-1:0]  frames,
   input logic [CNT_W-1:0]  entries
);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(src_addr) && $stable(dst_addr));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid && !busy);

   // R9
   empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && (frames == '0 || entries == '0) |=> done && !busy);

   // R5
   src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !flags[0] |-> src_addr == src_base);

   // R4
   src_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && flags[0] && !flags[1] |=> src_addr == $past(src_addr) + ADDR_W'(1));

endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.ADDR_W(ADDR_W), .FRM_W(FRM_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .src_addr  (src_addr),
   .dst_addr  (dst_addr),
   .busy      (busy),
   .done      (done),
   .flags     (flags_q),
   .src_base  (src_base_q),
   .frames    (frames_q),
   .entries   (entries_q)
);

// File: tb/ilv_addr_gen_bench.sv
module ilv_addr_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_data = '0;
   logic        tbl_we = 1'b0;
   logic [3:0]  tbl_idx = '0;
   logic [15:0] tbl_size = '0;
   logic [15:0] tbl_gap = '0;
   logic        start = 1'b0;
   logic        out_ready = 1'b0;
   logic        out_valid, busy, done;
   logic [31:0] src_addr, dst_addr;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   int          m_size [16];
   int          m_gap  [16];
   logic [3:0]  m_flags;
   int          m_frames, m_entries;

   always #2 clk = ~clk;

   ilv_addr_gen u_ilv_addr_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_size(tbl_size), .tbl_gap(tbl_gap),
      .start(start), .out_valid(out_valid), .out_ready(out_ready),
      .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "watchdog", cycles, 150000);
         finish_run();
      end
   end

   task automatic write_cfg(input int sel, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic write_tbl(input int i, input int sz, input int gp);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 4'(i); tbl_size = 16'(sz); tbl_gap = 16'(gp);
      m_size[i] = sz; m_gap[i] = gp;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic setup(input int nf, input int ne, input logic [3:0] fl);
      m_frames = nf; m_entries = ne; m_flags = fl;
      write_cfg(2, 32'(nf));
      write_cfg(3, 32'(ne));
      write_cfg(4, {28'd0, fl});
   endtask

   bit poke_pending;

   // waits for an accepted pair; also checks the stall hold
   task automatic wait_accept(input string req, output bit ok);
      logic [31:0] ps, pd;
      bit stalled = 0;
      ok = 0;
      for (int g = 0; g < 300; g++) begin
         @(negedge clk);
         start = 1'b0;
         if (poke_pending) begin
            start = 1'b1;
            poke_pending = 0;
         end
         if (stalled) begin
            check(out_valid && src_addr == ps && dst_addr == pd, "R10 stall hold", src_addr, ps);
         end
         out_ready = ($urandom % 4) != 0;
         if (out_valid && out_ready) begin
            ok = 1;
            return;
         end
         stalled = out_valid && !out_ready;
         ps = src_addr; pd = dst_addr;
      end
      check(1'b0, {req, " no pair offered"}, 0, 1);
   endtask

   // starts a transfer and compares every pair with the pattern model
   task automatic run_xfer(input logic [31:0] sa, input logic [31:0] da, input string req,
                           input bit exact_done, input bit poke);
      logic [31:0] s, d;
      int n = 0;
      int k = 0;
      bit ok;
      bit seen = 0;
      write_cfg(0, sa);
      write_cfg(1, da);
      @(negedge clk);
      start = 1'b1;
      s = sa; d = da;
      for (int f = 0; f < m_frames; f++) begin
         for (int e = 0; e < m_entries; e++) begin
            for (int b = 0; b < m_size[e]; b++) begin
               wait_accept(req, ok);
               if (!ok) return;
               check(src_addr == s, {req, " src"}, src_addr, s);
               check(dst_addr == d, {req, " dst"}, dst_addr, d);
               if (m_flags[0]) s = s + 1;
               if (m_flags[2]) d = d + 1;
               n++;
               if (poke && n == 2) poke_pending = 1;
            end
            if (m_flags[0] && m_flags[1]) s = s + 32'(m_gap[e]);
            if (m_flags[2] && m_flags[3]) d = d + 32'(m_gap[e]);
         end
      end
      for (int w = 0; w < 40; w++) begin
         @(negedge clk);
         start = 1'b0;
         out_ready = 1'b1;
         k++;
         if (out_valid) begin
            check(1'b0, "R7 extra pair after pattern", src_addr, 0);
            break;
         end
         if (done) begin
            seen = 1;
            break;
         end
      end
      check(seen, "R12 done raised", 32'(seen), 1);
      if (exact_done) check(k == 1, {req, " done timing"}, k, 1);
      @(negedge clk);
      check(!done && !busy, "R12 done single pulse", {30'd0, done, busy}, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      poke_pending = 0;
      for (int i = 0; i < 16; i++) begin m_size[i] = 0; m_gap[i] = 0; end
      #1;
      // R1 reset state
      check(!out_valid && !busy && !done, "R1 reset", {29'd0, out_valid, busy, done}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !busy && !done, "R1 after release", {29'd0, out_valid, busy, done}, 0);

      // R3 R6 R7: scattered source, packed destination, two frames
      write_tbl(0, 2, 4);
      write_tbl(1, 3, 0);
      write_tbl(2, 1, 7);
      setup(2, 3, 4'b0111);
      run_xfer(32'h1000, 32'h8000, "R3", 1, 0);

      // R5 R6: fixed source with skip flag set, scattered destination
      setup(2, 3, 4'b1110);
      run_xfer(32'h00F0_0000, 32'h2000, "R5", 1, 0);

      // R4: packed source, fixed destination
      setup(3, 3, 4'b0001);
      run_xfer(32'hFFFF_FFF0, 32'h40, "R4", 1, 0);

      // R8: zero-size entry in the middle still applies its skip
      write_tbl(1, 0, 5);
      setup(2, 3, 4'b1111);
      run_xfer(32'h3000, 32'h5000, "R8", 1, 0);

      // R8: zero-size final entry, done delayed by its step
      write_tbl(2, 0, 9);
      setup(2, 3, 4'b1011);
      run_xfer(32'h100, 32'h900, "R8 tail", 0, 0);

      // R9: empty transfers
      setup(0, 3, 4'b1111);
      run_xfer(32'h10, 32'h20, "R9 zero frames", 1, 0);
      setup(2, 0, 4'b1111);
      run_xfer(32'h10, 32'h20, "R9 zero entries", 1, 0);

      // R11: start during a busy transfer
      write_tbl(0, 3, 2);
      write_tbl(1, 2, 6);
      write_tbl(2, 4, 1);
      setup(2, 3, 4'b1111);
      run_xfer(32'h7000, 32'hA000, "R11", 1, 1);

      // R13: only the start addresses are reloaded
      run_xfer(32'h7100, 32'hB000, "R13", 1, 0);

      // R2 R7: random templates
      for (int it = 0; it < 8; it++) begin
         int ne = 1 + ($urandom % 6);
         for (int e = 0; e < ne; e++)
            write_tbl(e, (e == ne - 1) ? 1 + ($urandom % 4) : ($urandom % 5), $urandom % 20);
         setup(1 + ($urandom % 3), ne, 4'($urandom));
         run_xfer($urandom, $urandom, "R2 R7 random", 1, 0);
      end

      finish_run();
   end

endmodule